// File: doc/BRIEF.md
# VCXO Pull-Range Digital Scaler

This block turns a digitized control-voltage reading into a signed correction for the fractional feedback word of a synthesizer PLL. The 7-bit ADC code is centred on mid-scale, so the nominal control voltage (half the supply) gives no correction. The centred value is then multiplied by a 6-bit gain and by a fixed ppm-to-LSB constant. A single bit reverses the tuning slope. The result is clipped to the signed output width.

The configuration register block supplies the gain and the slope bit. Each ADC conversion comes with a one-cycle strobe. The scaler registers the new offset on that strobe and raises a valid flag for one cycle. The offset then holds until the next strobe. One conversion per cycle is accepted, so the update rate is limited only by the ADC and stays well above the 100 kHz modulation bandwidth.

Top module: `vcxo_pull_scaler`

## Requirements
- R1: After reset, `freq_offset` is 0 and `offset_vld` is 0.
- R2: An ADC code of 64 (mid-scale) produces an offset of 0 for every gain and slope setting.
- R3: With `slope_inv` = 0, the offset is (code − 64) × gain × SCALE, where SCALE defaults to 50 LSB per gain step per code step.
- R4: With `slope_inv` = 1, the offset is the two's-complement negation of the R3 value, before clipping.
- R5: A gain of 0 produces an offset of 0 for every ADC code.
- R6: Values above +2^(OUT_W−1)−1 clip to that limit, and values below −2^(OUT_W−1) clip to that limit. They never wrap. With the defaults the limits are +131071 and −131072.
- R7: The offset for a strobed sample appears on the clock edge that captures `sample_stb`. `offset_vld` is 1 for exactly that one cycle and 0 after a cycle with no strobe.
- R8: While `sample_stb` is low, `freq_offset` holds its value, even if the code, gain or slope inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe marking a new ADC code |
| adc_code | input | CODE_W (7) | Unsigned control-voltage code |
| pull_gain | input | GAIN_W (6) | Pull-range gain in 12.5 ppm steps |
| slope_inv | input | 1 | 1 = rising voltage lowers frequency |
| freq_offset | output | OUT_W (18) | Signed offset in fractional-word LSBs |
| offset_vld | output | 1 | High for one cycle when a new offset is loaded |

## Verification
The bench drives codes on both sides of mid-scale with small gains. These show whether the centring subtracts exactly 64 and whether the product is linear and correctly signed. The same codes are repeated with the slope bit set, which separates a true negation from a mere change of magnitude. Mid-scale and zero gain are applied at extreme settings, which exposes any residual bias. Full-scale codes at maximum gain in both slope settings drive the result past each limit, which separates clipping from wrap-around. A further case changes every input without a strobe, which shows whether the output register loads only on the strobe.

// File: rtl/vcxo_pull_scaler.sv
module vcxo_pull_scaler #(
  parameter int CODE_W  = 7,
  parameter int GAIN_W  = 6,
  parameter int OUT_W   = 18,
  parameter int SCALE_W = 8,
  parameter int SCALE   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [GAIN_W-1:0] pull_gain,
  input  logic              slope_inv,
  output logic [OUT_W-1:0]  freq_offset,
  output logic              offset_vld
);
  localparam int PROD_W = CODE_W + GAIN_W + SCALE_W + 4;
  localparam logic [CODE_W-1:0]  MID_V   = CODE_W'(1) << (CODE_W - 1);
  localparam logic [SCALE_W-1:0] SCALE_V = SCALE_W'(SCALE);
  localparam logic signed [PROD_W-1:0] MAX_P = PROD_W'((longint'(1) << (OUT_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MIN_P = ~MAX_P;

  logic signed [CODE_W:0]   centered;
  logic signed [PROD_W-1:0] mag, signed_prod;
  logic [OUT_W-1:0]         clipped;

  assign centered    = $signed({1'b0, adc_code}) - $signed({1'b0, MID_V});
  assign mag         = PROD_W'(centered) * PROD_W'($signed({1'b0, pull_gain}))
                       * PROD_W'($signed({1'b0, SCALE_V}));
  assign signed_prod = slope_inv ? -mag : mag;
  assign clipped     = (signed_prod > MAX_P) ? MAX_P[OUT_W-1:0] :
                       (signed_prod < MIN_P) ? MIN_P[OUT_W-1:0] :
                                               signed_prod[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_offset <= '0;
      offset_vld  <= 1'b0;
    end else begin
      offset_vld <= sample_stb;
      if (sample_stb) freq_offset <= clipped;
    end
  end
endmodule

// File: rtl/vcxo_pull_scaler_chk.sv
module vcxo_pull_scaler_chk #(
  parameter int CODE_W = 7,
  parameter int GAIN_W = 6,
  parameter int OUT_W  = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_stb,
  input logic [CODE_W-1:0] adc_code,
  input logic [GAIN_W-1:0] pull_gain,
  input logic              slope_inv,
  input logic [OUT_W-1:0]  freq_offset,
  input logic              offset_vld
);
  localparam logic [CODE_W-1:0] MID_C = CODE_W'(1) << (CODE_W - 1);

  // R7
  vld_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> offset_vld);
  // R7
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> !offset_vld);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(freq_offset));
  // R5
  zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && pull_gain == '0) |=> freq_offset == '0);
  // R2
  midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && adc_code == MID_C) |=> freq_offset == '0);
  // R4
  slope_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && pull_gain != '0 && adc_code > MID_C && slope_inv) |=> $signed(freq_offset) < 0);
endmodule

bind vcxo_pull_scaler vcxo_pull_scaler_chk #(.CODE_W(CODE_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .adc_code(adc_code),
  .pull_gain(pull_gain), .slope_inv(slope_inv), .freq_offset(freq_offset),
  .offset_vld(offset_vld));

// File: tb/sim_vcxo_pull_scaler.sv
`timescale 1ns/1ps
module sim_vcxo_pull_scaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_stb = 1'b0;
  logic [6:0]  adc_code = '0;
  logic [5:0]  pull_gain = '0;
  logic        slope_inv = 1'b0;
  logic [17:0] freq_offset;
  logic        offset_vld;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vcxo_pull_scaler u0 (.clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .adc_code(adc_code), .pull_gain(pull_gain), .slope_inv(slope_inv),
    .freq_offset(freq_offset), .offset_vld(offset_vld));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(input int c, input int g, input bit inv);
    longint p = longint'(c - 64) * g * 50;
    if (inv) p = -p;
    if (p > 131071) p = 131071;
    if (p < -131072) p = -131072;
    return p;
  endfunction

  task automatic sample(input int c, input int g, input bit inv, input string req);
    longint e = model(c, g, inv);
    @(negedge clk);
    adc_code = 7'(c); pull_gain = 6'(g); slope_inv = inv; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    check({req, " value"}, longint'($signed(freq_offset)), e);
    check("R7 vld high", longint'(offset_vld), 1);
    @(negedge clk);
    check("R7 vld one cycle", longint'(offset_vld), 0);
  endtask

  task automatic test_reset();
    check("R1 offset", longint'(freq_offset), 0);
    check("R1 vld", longint'(offset_vld), 0);
  endtask

  task automatic test_linear();
    sample(65, 1, 0, "R3");
    sample(63, 1, 0, "R3");
    sample(80, 7, 0, "R3");
    sample(40, 12, 0, "R3");
  endtask

  task automatic test_invert();
    sample(80, 7, 1, "R4");
    sample(40, 12, 1, "R4");
  endtask

  task automatic test_midscale();
    sample(64, 63, 0, "R2");
    sample(64, 63, 1, "R2");
  endtask

  task automatic test_zero_gain();
    sample(127, 0, 0, "R5");
    sample(0, 0, 1, "R5");
  endtask

  task automatic test_clip();
    sample(127, 63, 0, "R6");
    sample(0, 63, 0, "R6");
    sample(127, 63, 1, "R6");
    sample(0, 63, 1, "R6");
    sample(105, 63, 0, "R6");
  endtask

  task automatic test_hold();
    sample(70, 3, 0, "R8 setup");
    @(negedge clk);
    adc_code = 7'd0; pull_gain = 6'd63; slope_inv = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 hold", longint'($signed(freq_offset)), model(70, 3, 0));
    check("R7 no strobe vld", longint'(offset_vld), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_linear();
    test_invert();
    test_midscale();
    test_zero_gain();
    test_clip();
    test_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule